// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block launches commands on behalf of an SD/MMC host controller. Software programs a 32-bit argument and then writes a command word. The command word holds the command index, the expected response kind and three flags: response CRC check, response index check and data present. Writing the command word asks for a launch. The launch is granted only when the command path is free. The data path must also be free, unless the command is the stop-transmission command. When a launch is granted, the block sends a one-cycle start strobe to an external serializer, together with the index, the argument and the response kind.

The serializer reports back a response payload and its line status. The block stores the response in four read-only words. A long (136-bit) response is stored with its check byte removed and every word already shifted, so software reads a contiguous 128-bit image. The block also records completion and error events in a write-one-to-clear status word. For a response kind that signals busy, the command counts as complete only when both the response and the data-end indication have arrived, in either order. A counter that runs on card-clock ticks stops a command that never receives a response.

Top module: `sdcmd_issue_unit`

## Requirements
- R1: A command-word write (address 1) while the command inhibit (present word bit 0) is set does not launch. No start strobe follows, and the command readback at address 1 keeps the last launched word.
- R2: A command-word write while only the data inhibit (present word bit 1) is set does not launch, unless the written index (command word bits 13:8) equals STOP_IDX (default 12). In that case the command launches.
- R3: An accepted command-word write is followed in the next cycle by exactly one cycle of `ser_start`, carrying the index, the argument last written to address 0, and the response kind from command word bits 1:0. The kinds are 0 none, 1 long, 2 short, 3 short-with-busy.
- R4: A launch with kind 1, 2 or 3 sets the command inhibit. A clean response clears it for kinds 1 and 2. A launch with kind 0 leaves it clear and sets the command-complete status bit (bit 2) at once.
- R5: A launch with data present (command word bit 5) or with kind 3 sets the data inhibit. A `dat_end` pulse clears the data inhibit and sets the data-end status bit (bit 1).
- R6: A short response stores payload bits 31:0 in response word 0 (address 4) and zero in words 1 to 3 (addresses 5 to 7).
- R7: A long response stores the 120-bit payload shifted left by 8 bits across the four response words. Word 0 has a zero low byte, and word 3 holds payload bits 119:88.
- R8: For kind 3, a clean response sets response-done (bit 0). Command-complete (bit 2) and the clearing of the command inhibit wait until `dat_end` has also been seen; `dat_end` may come before or after the response.
- R9: With the CRC check flag (bit 3) set, a response with `ser_rsp_crc_ok` low sets the CRC error bit (bit 4). With the index check flag (bit 4) set, a response whose index differs from the command's sets the index error bit (bit 6). With a flag clear, its check is skipped. A low `ser_rsp_end_ok` always sets the end-bit error bit (bit 5).
- R10: If no response arrives within TMO_TICKS `card_tick` pulses after a launch, the command-timeout bit (bit 3) is set.
- R11: Any error ends the command. The command inhibit clears, response-done and command-complete stay clear, and a response arriving after a timeout is ignored: the status and the response words are unchanged.
- R12: Writing to the status word (address 3) clears each bit written as 1. An event that sets a bit in the same cycle wins over the clear.
- R13: Status bit 15 reads as the OR of the four error bits (bits 3 to 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read word address |
| reg_rdata | output | 32 | Register read data (combinational) |
| ser_start | output | 1 | One-cycle launch strobe to the serializer |
| ser_index | output | 6 | Index of the launched command |
| ser_arg | output | 32 | Argument of the launched command |
| ser_rsp_kind | output | 2 | Expected response kind |
| ser_rsp_valid | input | 1 | Response present from the serializer |
| ser_rsp_index | input | 6 | Index field of the received response |
| ser_rsp_crc_ok | input | 1 | Response check sequence was correct |
| ser_rsp_end_ok | input | 1 | Response end bit was correct |
| ser_rsp_payload | input | 120 | Response content without the check byte |
| card_tick | input | 1 | One pulse per card clock, for the timeout |
| dat_end | input | 1 | Data-end pulse from the data path |

## Verification
The checker module looks at every cycle and confirms four things. No start strobe follows a command write that the inhibit rules reject, both for the command path and for the data path outside the stop exception. The strobe never lasts more than one cycle, and a command that expects a response holds the command inhibit while its strobe is out. It also confirms that a timeout is raised only while a command is waiting and that data end leaves the data inhibit clear. The register contents need the bench's directed scenarios. These cover the shifted long-response image, clearing of the upper words on a short response, busy completion in both arrival orders, which checks each flag enables, the exact timeout tick count, a late response being dropped, and a write-one clear racing a set.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int DW        = 32;
  localparam int IDXW      = 6;
  localparam int RSP_WORDS = 4;
  localparam int RSPW      = RSP_WORDS * DW;
  localparam int PAYW      = RSPW - 8;
  localparam int NSTAT     = 7;

  localparam logic [2:0] A_ARG  = 3'd0;
  localparam logic [2:0] A_CMD  = 3'd1;
  localparam logic [2:0] A_PRES = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;

  localparam int S_RSP  = 0;
  localparam int S_DEND = 1;
  localparam int S_CDONE = 2;
  localparam int S_TMO  = 3;
  localparam int S_CRC  = 4;
  localparam int S_END  = 5;
  localparam int S_IDX  = 6;
  localparam int S_ERRSUM = 15;

  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_LONG  = 2'd1,
    RK_SHORT = 2'd2,
    RK_BUSY  = 2'd3
  } rsp_kind_e;

  typedef struct packed {
    logic [IDXW-1:0] idx;
    logic            data;
    logic            idx_chk;
    logic            crc_chk;
    rsp_kind_e       kind;
  } cmd_word_t;

  function automatic cmd_word_t decode_cmd(input logic [DW-1:0] w);
    cmd_word_t c;
    c.idx     = w[13:8];
    c.data    = w[5];
    c.idx_chk = w[4];
    c.crc_chk = w[3];
    c.kind    = rsp_kind_e'(w[1:0]);
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_launch_ctl.sv
module sdcmd_launch_ctl
  import sdcmd_pkg::*;
#(
  parameter int TMO_TICKS = 1024,
  parameter int STOP_IDX  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr_i,
  input  cmd_word_t       cmd_i,
  input  logic            rsp_valid_i,
  input  logic [IDXW-1:0] rsp_index_i,
  input  logic            rsp_crc_ok_i,
  input  logic            rsp_end_ok_i,
  input  logic            card_tick_i,
  input  logic            dat_end_i,
  output logic            launch_o,
  output logic            start_o,
  output cmd_word_t       act_o,
  output logic            cmd_inh_o,
  output logic            dat_inh_o,
  output logic            rsp_take_o,
  output logic [NSTAT-1:0] ev_o
);

  localparam int CNTW = $clog2(TMO_TICKS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_RSP, ST_WAIT_BUSY} st_e;

  st_e             st_q, st_d;
  cmd_word_t       act_q;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            end_seen_q, end_seen_d;
  logic            dat_inh_q, dat_inh_d;
  logic            start_q;

  logic launch, rsp_take, crc_bad, idx_bad, end_bad, rsp_err, rsp_clean, tmo;
  logic cmd_done;

  always_comb begin
    launch   = cmd_wr_i && (st_q == ST_IDLE) &&
               (!dat_inh_q || (cmd_i.idx == IDXW'(STOP_IDX)));
    rsp_take = rsp_valid_i && (st_q == ST_WAIT_RSP);
    crc_bad  = rsp_take && act_q.crc_chk && !rsp_crc_ok_i;
    idx_bad  = rsp_take && act_q.idx_chk && (rsp_index_i != act_q.idx);
    end_bad  = rsp_take && !rsp_end_ok_i;
    rsp_err  = crc_bad || idx_bad || end_bad;
    rsp_clean = rsp_take && !rsp_err;
    tmo      = (st_q == ST_WAIT_RSP) && !rsp_valid_i && card_tick_i &&
               (cnt_q == CNTW'(TMO_TICKS - 1));
  end

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    end_seen_d = end_seen_q;
    cmd_done   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (launch) begin
          cnt_d      = '0;
          end_seen_d = 1'b0;
          if (cmd_i.kind == RK_NONE) cmd_done = 1'b1;
          else                       st_d = ST_WAIT_RSP;
        end
      end
      ST_WAIT_RSP: begin
        if (dat_end_i) end_seen_d = 1'b1;
        if (rsp_take) begin
          if (rsp_err) begin
            st_d = ST_IDLE;
          end else if (act_q.kind != RK_BUSY || end_seen_q || dat_end_i) begin
            st_d     = ST_IDLE;
            cmd_done = 1'b1;
          end else begin
            st_d = ST_WAIT_BUSY;
          end
        end else if (tmo) begin
          st_d = ST_IDLE;
        end else if (card_tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAIT_BUSY: begin
        if (dat_end_i) begin
          st_d     = ST_IDLE;
          cmd_done = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    dat_inh_d = dat_inh_q;
    if (dat_end_i) dat_inh_d = 1'b0;
    if (launch && (cmd_i.data || cmd_i.kind == RK_BUSY)) dat_inh_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      end_seen_q <= 1'b0;
      dat_inh_q  <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      end_seen_q <= end_seen_d;
      dat_inh_q  <= dat_inh_d;
      start_q    <= launch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (launch) begin
      act_q <= cmd_i;
    end
  end

  always_comb begin
    ev_o        = '0;
    ev_o[S_RSP]  = rsp_clean;
    ev_o[S_DEND] = dat_end_i;
    ev_o[S_CDONE] = cmd_done;
    ev_o[S_TMO]  = tmo;
    ev_o[S_CRC]  = crc_bad;
    ev_o[S_END]  = end_bad;
    ev_o[S_IDX]  = idx_bad;
  end

  assign launch_o   = launch;
  assign start_o    = start_q;
  assign act_o      = act_q;
  assign cmd_inh_o  = (st_q != ST_IDLE);
  assign dat_inh_o  = dat_inh_q;
  assign rsp_take_o = rsp_take;

endmodule

// File: rtl/sdcmd_resp_store.sv
module sdcmd_resp_store
  import sdcmd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take_i,
  input  rsp_kind_e                     kind_i,
  input  logic [PAYW-1:0]               payload_i,
  output logic [RSP_WORDS-1:0][DW-1:0]  words_o
);

  logic [RSPW-1:0] img_d, img_q;

  always_comb begin
    if (kind_i == RK_LONG) img_d = {payload_i, 8'h00};
    else                   img_d = {{(RSPW-DW){1'b0}}, payload_i[DW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_q <= '0;
    end else if (take_i) begin
      img_q <= img_d;
    end
  end

  for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
    assign words_o[w] = img_q[w*DW +: DW];
  end

endmodule

// File: rtl/sdcmd_irq_stat.sv
module sdcmd_irq_stat #(
  parameter int NB = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_i,
  input  logic          clr_wr_i,
  input  logic [NB-1:0] clr_mask_i,
  output logic [NB-1:0] stat_o
);

  logic [NB-1:0] stat_d, stat_q;

  for (genvar b = 0; b < NB; b++) begin : g_bit
    always_comb begin
      stat_d[b] = set_i[b] | (stat_q[b] & ~(clr_wr_i & clr_mask_i[b]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/sdcmd_issue_unit.sv
module sdcmd_issue_unit
  import sdcmd_pkg::*;
#(
  parameter int TMO_TICKS = 1024,
  parameter int STOP_IDX  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_waddr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic [2:0]       reg_raddr,
  output logic [DW-1:0]    reg_rdata,
  output logic             ser_start,
  output logic [IDXW-1:0]  ser_index,
  output logic [DW-1:0]    ser_arg,
  output logic [1:0]       ser_rsp_kind,
  input  logic             ser_rsp_valid,
  input  logic [IDXW-1:0]  ser_rsp_index,
  input  logic             ser_rsp_crc_ok,
  input  logic             ser_rsp_end_ok,
  input  logic [PAYW-1:0]  ser_rsp_payload,
  input  logic             card_tick,
  input  logic             dat_end
);

  logic [DW-1:0] arg_q, cmd_q, arg_act_q;
  logic          arg_we, cmd_wr, stat_wr;
  logic          launch, rsp_take, cmd_inh, dat_inh;
  cmd_word_t     act;
  logic [NSTAT-1:0] ev, stat_q;
  logic [RSP_WORDS-1:0][DW-1:0] rsp_words;
  logic          err_any;

  assign arg_we  = reg_wr && (reg_waddr == A_ARG);
  assign cmd_wr  = reg_wr && (reg_waddr == A_CMD);
  assign stat_wr = reg_wr && (reg_waddr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arg_q <= '0;
    else if (arg_we) arg_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      arg_act_q <= '0;
    end else if (launch) begin
      cmd_q     <= reg_wdata;
      arg_act_q <= arg_q;
    end
  end

  sdcmd_launch_ctl #(
    .TMO_TICKS (TMO_TICKS),
    .STOP_IDX  (STOP_IDX)
  ) launch_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr_i     (cmd_wr),
    .cmd_i        (decode_cmd(reg_wdata)),
    .rsp_valid_i  (ser_rsp_valid),
    .rsp_index_i  (ser_rsp_index),
    .rsp_crc_ok_i (ser_rsp_crc_ok),
    .rsp_end_ok_i (ser_rsp_end_ok),
    .card_tick_i  (card_tick),
    .dat_end_i    (dat_end),
    .launch_o     (launch),
    .start_o      (ser_start),
    .act_o        (act),
    .cmd_inh_o    (cmd_inh),
    .dat_inh_o    (dat_inh),
    .rsp_take_o   (rsp_take),
    .ev_o         (ev)
  );

  sdcmd_resp_store store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (rsp_take),
    .kind_i    (act.kind),
    .payload_i (ser_rsp_payload),
    .words_o   (rsp_words)
  );

  sdcmd_irq_stat #(.NB(NSTAT)) stat_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (ev),
    .clr_wr_i   (stat_wr),
    .clr_mask_i (reg_wdata[NSTAT-1:0]),
    .stat_o     (stat_q)
  );

  assign err_any = |stat_q[S_IDX:S_TMO];

  always_comb begin
    reg_rdata = '0;
    unique case (reg_raddr)
      A_ARG:  reg_rdata = arg_q;
      A_CMD:  reg_rdata = cmd_q;
      A_PRES: reg_rdata = {{(DW-2){1'b0}}, dat_inh, cmd_inh};
      A_STAT: begin
        reg_rdata[NSTAT-1:0] = stat_q;
        reg_rdata[S_ERRSUM]  = err_any;
      end
      default: reg_rdata = rsp_words[reg_raddr[1:0]];
    endcase
  end

  assign ser_index    = act.idx;
  assign ser_arg      = arg_act_q;
  assign ser_rsp_kind = 2'(act.kind);

endmodule

// File: rtl/sdcmd_issue_unit_chk.sv
module sdcmd_issue_unit_chk
  import sdcmd_pkg::*;
#(
  parameter int STOP_IDX = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [2:0]      reg_waddr,
  input logic [IDXW-1:0] wr_index,
  input logic            ser_start,
  input logic [1:0]      ser_rsp_kind,
  input logic            cmd_inh,
  input logic            dat_inh,
  input logic            dat_end,
  input logic            tmo_flag
);

  logic cmd_write;
  assign cmd_write = reg_wr && (reg_waddr == A_CMD);

  // R1
  cmd_inh_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_write && cmd_inh) |=> !ser_start);

  // R2
  dat_inh_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_write && !cmd_inh && dat_inh && (wr_index != IDXW'(STOP_IDX))) |=> !ser_start);

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start |=> !ser_start);

  // R4
  rsp_cmd_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_start && (ser_rsp_kind != 2'd0)) |-> cmd_inh);

  // R5
  dat_end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_end && !cmd_write) |=> !dat_inh);

  // R10
  tmo_when_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(cmd_inh));

endmodule

bind sdcmd_issue_unit sdcmd_issue_unit_chk #(.STOP_IDX(STOP_IDX)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_waddr    (reg_waddr),
  .wr_index     (reg_wdata[13:8]),
  .ser_start    (ser_start),
  .ser_rsp_kind (ser_rsp_kind),
  .cmd_inh      (cmd_inh),
  .dat_inh      (dat_inh),
  .dat_end      (dat_end),
  .tmo_flag     (stat_q[sdcmd_pkg::S_TMO])
);

// File: tb/sdcmd_issue_unit_tb_top.sv
module sdcmd_issue_unit_tb_top;

  localparam int TMO = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_waddr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [2:0]   reg_raddr = '0;
  logic [31:0]  reg_rdata;
  logic         ser_start;
  logic [5:0]   ser_index;
  logic [31:0]  ser_arg;
  logic [1:0]   ser_rsp_kind;
  logic         ser_rsp_valid = 1'b0;
  logic [5:0]   ser_rsp_index = '0;
  logic         ser_rsp_crc_ok = 1'b1;
  logic         ser_rsp_end_ok = 1'b1;
  logic [119:0] ser_rsp_payload = '0;
  logic         card_tick = 1'b0;
  logic         dat_end = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdcmd_issue_unit #(.TMO_TICKS(TMO), .STOP_IDX(12)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .ser_start(ser_start), .ser_index(ser_index), .ser_arg(ser_arg),
    .ser_rsp_kind(ser_rsp_kind),
    .ser_rsp_valid(ser_rsp_valid), .ser_rsp_index(ser_rsp_index),
    .ser_rsp_crc_ok(ser_rsp_crc_ok), .ser_rsp_end_ok(ser_rsp_end_ok),
    .ser_rsp_payload(ser_rsp_payload),
    .card_tick(card_tick), .dat_end(dat_end)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_raddr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic rsp(input logic [5:0] idx, input logic crc_ok, input logic end_ok,
                     input logic [119:0] pay);
    @(negedge clk);
    ser_rsp_valid = 1'b1; ser_rsp_index = idx;
    ser_rsp_crc_ok = crc_ok; ser_rsp_end_ok = end_ok; ser_rsp_payload = pay;
    @(negedge clk);
    ser_rsp_valid = 1'b0; ser_rsp_crc_ok = 1'b1; ser_rsp_end_ok = 1'b1;
  endtask

  task automatic dend();
    @(negedge clk);
    dat_end = 1'b1;
    @(negedge clk);
    dat_end = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic clr_all();
    wr(3'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    check("R3 reset start", {31'b0, ser_start}, 32'h0);
    expect_reg("R4 reset present", 3'd2, 32'h0);
    expect_reg("R12 reset status", 3'd3, 32'h0);
    expect_reg("R6 reset resp0", 3'd4, 32'h0);
  endtask

  task automatic t_no_rsp();
    wr(3'd0, 32'hA5A5_0001);
    wr(3'd1, 32'h0000_0000);
    check("R3 start high", {31'b0, ser_start}, 32'h1);
    check("R3 index", {26'b0, ser_index}, 32'h0);
    check("R3 arg", ser_arg, 32'hA5A5_0001);
    check("R3 kind", {30'b0, ser_rsp_kind}, 32'h0);
    expect_reg("R4 none present", 3'd2, 32'h0);
    expect_reg("R4 none complete", 3'd3, 32'h4);
    @(negedge clk);
    check("R3 start one cycle", {31'b0, ser_start}, 32'h0);
    clr_all();
    expect_reg("R12 cleared", 3'd3, 32'h0);
  endtask

  task automatic t_short();
    wr(3'd0, 32'h0000_1234);
    wr(3'd1, 32'h0000_111A);
    check("R3 short index", {26'b0, ser_index}, 32'd17);
    check("R3 short kind", {30'b0, ser_rsp_kind}, 32'h2);
    expect_reg("R4 short inhibit", 3'd2, 32'h1);
    rsp(6'd17, 1'b1, 1'b1, {88'hFF_0000_0000_0000_0000_0001, 32'hDEAD_BEEF});
    expect_reg("R4 short released", 3'd2, 32'h0);
    expect_reg("R4 short status", 3'd3, 32'h5);
    expect_reg("R6 word0", 3'd4, 32'hDEAD_BEEF);
    expect_reg("R6 word1", 3'd5, 32'h0);
    expect_reg("R6 word3", 3'd7, 32'h0);
    clr_all();
  endtask

  task automatic t_long();
    wr(3'd1, 32'h0000_0209);
    rsp(6'd63, 1'b1, 1'b1, 120'h11223344_55667788_99AABBCC_DDEEFF);
    expect_reg("R7 word3", 3'd7, 32'h1122_3344);
    expect_reg("R7 word2", 3'd6, 32'h5566_7788);
    expect_reg("R7 word1", 3'd5, 32'h99AA_BBCC);
    expect_reg("R7 word0", 3'd4, 32'hDDEE_FF00);
    expect_reg("R7 status", 3'd3, 32'h5);
    clr_all();
  endtask

  task automatic t_cmd_inhibit();
    wr(3'd1, 32'h0000_0502);
    wr(3'd1, 32'h0000_0602);
    check("R1 no start", {31'b0, ser_start}, 32'h0);
    expect_reg("R1 readback kept", 3'd1, 32'h0000_0502);
    rsp(6'd5, 1'b1, 1'b1, '0);
    clr_all();
  endtask

  task automatic t_stop();
    wr(3'd1, 32'h0000_1222);
    expect_reg("R5 data inhibit set", 3'd2, 32'h3);
    rsp(6'd18, 1'b1, 1'b1, '0);
    expect_reg("R5 data still busy", 3'd2, 32'h2);
    clr_all();
    wr(3'd1, 32'h0000_0D02);
    check("R2 blocked", {31'b0, ser_start}, 32'h0);
    expect_reg("R2 readback kept", 3'd1, 32'h0000_1222);
    wr(3'd1, 32'h0000_0C03);
    check("R2 stop launches", {31'b0, ser_start}, 32'h1);
    expect_reg("R2 present", 3'd2, 32'h3);
    rsp(6'd12, 1'b1, 1'b1, '0);
    expect_reg("R8 wait busy status", 3'd3, 32'h1);
    expect_reg("R8 wait busy present", 3'd2, 32'h3);
    dend();
    expect_reg("R8 busy complete", 3'd3, 32'h7);
    expect_reg("R5 all released", 3'd2, 32'h0);
    clr_all();
  endtask

  task automatic t_busy_early();
    wr(3'd1, 32'h0000_0703);
    expect_reg("R5 busy sets data inhibit", 3'd2, 32'h3);
    dend();
    expect_reg("R5 data end status", 3'd3, 32'h2);
    expect_reg("R8 early end present", 3'd2, 32'h1);
    rsp(6'd7, 1'b1, 1'b1, '0);
    expect_reg("R8 early end complete", 3'd3, 32'h7);
    expect_reg("R8 early end free", 3'd2, 32'h0);
    clr_all();
  endtask

  task automatic t_errors();
    wr(3'd1, 32'h0000_091A);
    rsp(6'd8, 1'b0, 1'b1, '0);
    expect_reg("R9 crc and index error", 3'd3, 32'h0000_8050);
    expect_reg("R11 inhibit cleared", 3'd2, 32'h0);
    clr_all();
    expect_reg("R13 summary clears", 3'd3, 32'h0);
    wr(3'd1, 32'h0000_0902);
    rsp(6'd8, 1'b0, 1'b1, '0);
    expect_reg("R9 checks disabled", 3'd3, 32'h5);
    clr_all();
    wr(3'd1, 32'h0000_0902);
    rsp(6'd9, 1'b1, 1'b0, 120'h0000_1111);
    expect_reg("R9 end bit error", 3'd3, 32'h0000_8020);
    clr_all();
  endtask

  task automatic t_timeout();
    logic [31:0] w0;
    rd(3'd4, w0);
    wr(3'd1, 32'h0000_0302);
    card_tick = 1'b1;
    for (int i = 0; i < TMO - 1; i++) @(negedge clk);
    expect_reg("R10 before limit", 3'd3, 32'h0);
    expect_reg("R10 still waiting", 3'd2, 32'h1);
    @(negedge clk);
    card_tick = 1'b0;
    expect_reg("R10 timeout", 3'd3, 32'h0000_8008);
    expect_reg("R11 timeout releases", 3'd2, 32'h0);
    rsp(6'd3, 1'b1, 1'b1, 120'hCAFE);
    expect_reg("R11 late status", 3'd3, 32'h0000_8008);
    expect_reg("R11 late resp ignored", 3'd4, w0);
    clr_all();
  endtask

  task automatic t_w1c();
    wr(3'd1, 32'h0000_0000);
    dend();
    expect_reg("R12 two bits", 3'd3, 32'h6);
    wr(3'd3, 32'h0000_0002);
    expect_reg("R12 partial clear", 3'd3, 32'h4);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = 3'd3; reg_wdata = 32'h2; dat_end = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; dat_end = 1'b0;
    expect_reg("R12 set wins", 3'd3, 32'h6);
    clr_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_rsp();
    t_short();
    t_long();
    t_cmd_inhibit();
    t_stop();
    t_busy_early();
    t_errors();
    t_timeout();
    t_w1c();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule